// File: doc/BRIEF.md
# Cartridge Save-Memory Window Controller

This block sits between a 68000-style CPU bus and a cartridge's battery-backed save storage. The CPU presents a 24-bit address, a size code, a read or write strobe, write data and a free-running CPU cycle count. Any access inside a movable address window is served either by a small byte-wide SRAM held in the block or by a bit-banged serial EEPROM port. Any access outside that window falls through to the ROM path.

The block works out for itself which kind of save device the cartridge carries. It does this from the first access that lands in the window. A write to either of the two lowest window bytes before detection marks the device as EEPROM and shrinks the window to those two bytes. Any other early access marks the device as plain SRAM. In EEPROM mode, line writes that follow each other closely in CPU cycles are merged: only the latest line levels are kept, and the previously pending SCL/SDA pair is forwarded to the EEPROM protocol engine only when enough cycles have passed. A sticky flag tells the system when save contents have changed.

Top module: `swin_ctrl`

## Requirements
- R1: After reset the mode state is all zero, the window spans 0x200000 to 0x20FFFF, every stored byte reads as zero, and `save_changed` and `ee_strobe` are low.
- R2: An access is served (`rd_hit` high on a read) only when the address lies inclusively within the window and either SRAM is enabled or EEPROM mode is active. A read that is not served returns zero. The SRAM-enable and write-disable state follow `cfg_sram_en` and `cfg_wr_dis` one clock later.
- R3: A served write before detection marks the device as detected. If that write targets 0x200000 or 0x200001, it also turns on EEPROM mode and narrows the window to 0x200000–0x200001. The detecting write itself is still handled under the mode that was in force before it.
- R4: A served read before detection, with SRAM enabled and an address above 0x200001, marks the device as detected plain SRAM: the window stays as it was, and halfword writes take the direct path of R9.
- R5: In EEPROM mode, a byte-path write is merged if it arrives fewer than 46 CPU cycles after the last forwarded write. A merged write only replaces the pending line pair (SCL = data bit 1, SDA = data bit 0). Otherwise the previously pending pair appears on `ee_scl`/`ee_sda` with a one-cycle `ee_strobe` in the clock after the write, the new pair becomes pending, and the timestamp is refreshed. EEPROM writes leave the stored bytes and `save_changed` untouched.
- R6: A byte-path SRAM write stores `bus_wdata[7:0]` unless writes are disabled. It raises `save_changed` only when the new value differs from the stored byte.
- R7: `chg_clr` clears `save_changed`. A write that sets the flag in the same clock wins over the clear.
- R8: Size codes are 0 = byte, 1 = halfword, 2 = word. A byte read returns the byte in bits 7:0. A halfword read returns the byte at the address in both bytes of bits 15:0. A word read returns the byte at the address in bits 31:16 (both bytes) and the byte at address+2 in bits 15:0 (both bytes).
- R9: A halfword or word write, when the device is detected, not EEPROM and write-enabled, stores `bus_wdata[15:8]` at the address and `bus_wdata[7:0]` at address+1. It always raises `save_changed`.
- R10: In any other mode, a halfword or word write takes the byte path of R5/R6 with `bus_wdata[7:0]` at the address only.
- R11: In EEPROM mode, the byte value seen by a read is `ee_dout` in bit 0 with the other seven bits zero, replicated per R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sram_en | input | 1 | Save SRAM enable setting |
| cfg_wr_dis | input | 1 | Save SRAM write-protect setting |
| bus_addr | input | 24 | CPU byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| cpu_cyc | input | 32 | Free-running CPU cycle count |
| ee_dout | input | 1 | Data-out bit from the EEPROM engine |
| chg_clr | input | 1 | Clears the changed flag |
| rd_hit | output | 1 | Read is served by the save logic |
| rd_data | output | 32 | Read data (combinational) |
| ee_strobe | output | 1 | One-cycle pulse forwarding a line pair |
| ee_scl | output | 1 | Forwarded SCL level |
| ee_sda | output | 1 | Forwarded SDA level |
| save_changed | output | 1 | Sticky save-contents-changed flag |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together. They also assume that `cpu_cyc` only moves forward, so the difference to the stored timestamp is a true distance, and that address, size and data stay steady while a strobe is high. The bench drives one strobe per access at the falling edge, holds it for one clock and then idles for one clock. It gives every EEPROM write an explicit, increasing cycle count, chosen to land just below, exactly at and well past the merge distance.

// File: rtl/swin_pkg.sv
package swin_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   // bit positions inside the mode register
   localparam int MB_SRAM  = 0;
   localparam int MB_WRDIS = 1;
   localparam int MB_EE    = 2;
   localparam int MB_DET   = 4;
   localparam int MB_SDA   = 6;
   localparam int MB_SCL   = 7;
endpackage

// File: rtl/swin_mode.sv
module swin_mode #(
   parameter int                ADDR_W    = 24,
   parameter logic [ADDR_W-1:0] WIN_START = 24'h200000,
   parameter logic [ADDR_W-1:0] WIN_END   = 24'h20FFFF,
   parameter logic [ADDR_W-1:0] EE_LO     = 24'h200000,
   parameter logic [ADDR_W-1:0] EE_HI     = 24'h200001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sram_en,
   input  logic              cfg_wr_dis,
   input  logic              rd_sel,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              pend_we,
   input  logic [1:0]        pend_val,
   output logic [7:0]        mode_q,
   output logic [ADDR_W-1:0] win_lo,
   output logic [ADDR_W-1:0] win_hi
);
   import swin_pkg::*;

   logic ee_target;
   assign ee_target = (addr >= EE_LO) && (addr <= EE_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         win_lo <= WIN_START;
         win_hi <= WIN_END;
      end else begin
         mode_q[MB_SRAM]  <= cfg_sram_en;
         mode_q[MB_WRDIS] <= cfg_wr_dis;
         if (pend_we) begin
            mode_q[MB_SCL] <= pend_val[1];
            mode_q[MB_SDA] <= pend_val[0];
         end
         if (wr_sel && !mode_q[MB_DET]) begin
            mode_q[MB_DET] <= 1'b1;
            if (ee_target) begin
               mode_q[MB_EE] <= 1'b1;
               win_lo        <= EE_LO;
               win_hi        <= EE_HI;
            end
         end else if (rd_sel && !mode_q[MB_DET] && mode_q[MB_SRAM] && (addr > EE_HI)) begin
            mode_q[MB_DET] <= 1'b1;
         end
      end
   end

   // R3 R4
   det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[MB_DET] |=> mode_q[MB_DET]);

   // R3
   ee_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[MB_EE] |-> (mode_q[MB_DET] && win_lo == EE_LO && win_hi == EE_HI));
endmodule

// File: rtl/swin_eecoal.sv
module swin_eecoal #(
   parameter int CYC_W  = 32,
   parameter int EE_GAP = 46
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ee_wr,
   input  logic [1:0]       wr_bits,
   input  logic [CYC_W-1:0] cyc,
   input  logic [1:0]       pend_cur,
   output logic             pend_we,
   output logic [1:0]       pend_val,
   output logic             ee_strobe,
   output logic             ee_scl,
   output logic             ee_sda
);
   localparam logic [CYC_W-1:0] GAP_C = CYC_W'(EE_GAP);

   logic [CYC_W-1:0] last_q;
   logic             near;

   assign near     = (cyc - last_q) < GAP_C;
   assign pend_we  = ee_wr;
   assign pend_val = wr_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q    <= '0;
         ee_strobe <= 1'b0;
         ee_scl    <= 1'b0;
         ee_sda    <= 1'b0;
      end else begin
         ee_strobe <= 1'b0;
         if (ee_wr && !near) begin
            ee_strobe <= 1'b1;
            ee_scl    <= pend_cur[1];
            ee_sda    <= pend_cur[0];
            last_q    <= cyc;
         end
      end
   end

   // R5
   strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ee_strobe |-> $past(ee_wr));

   // R5
   merge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_wr && near) |=> (!ee_strobe && $stable(ee_scl) && $stable(ee_sda)));
endmodule

// File: rtl/swin_store.sv
module swin_store #(
   parameter int DEPTH_LOG2 = 6,
   parameter bit MEM_CLEAR  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DEPTH_LOG2-1:0] idx,
   input  logic                  wr_byte_en,
   input  logic                  wr_half_en,
   input  logic [15:0]           wdata,
   input  logic                  chg_clr,
   output logic [7:0]            rd_b0,
   output logic [7:0]            rd_b2,
   output logic                  changed
);
   localparam int DEPTH = 1 << DEPTH_LOG2;

   logic [DEPTH*8-1:0]    mem_flat;
   logic [DEPTH_LOG2-1:0] idx1;
   logic [DEPTH_LOG2-1:0] idx2;
   logic                  byte_commit;

   assign idx1        = idx + DEPTH_LOG2'(1);
   assign idx2        = idx + DEPTH_LOG2'(2);
   assign rd_b0       = mem_flat[{idx, 3'b000} +: 8];
   assign rd_b2       = mem_flat[{idx2, 3'b000} +: 8];
   assign byte_commit = wr_byte_en && (rd_b0 != wdata[7:0]);

   for (genvar e = 0; e < DEPTH; e++) begin : g_cell
      localparam logic [DEPTH_LOG2-1:0] E_IDX = DEPTH_LOG2'(e);
      logic       we_e;
      logic [7:0] wd_e;
      logic [7:0] cell_q;

      always_comb begin
         we_e = (byte_commit && idx == E_IDX) ||
                (wr_half_en && (idx == E_IDX || idx1 == E_IDX));
         if (wr_half_en)
            wd_e = (idx == E_IDX) ? wdata[15:8] : wdata[7:0];
         else
            wd_e = wdata[7:0];
      end

      if (MEM_CLEAR) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cell_q <= '0;
            else if (we_e) cell_q <= wd_e;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (we_e) cell_q <= wd_e;
         end
      end

      assign mem_flat[e*8 +: 8] = cell_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         changed <= 1'b0;
      else if (byte_commit || wr_half_en) changed <= 1'b1;
      else if (chg_clr)                   changed <= 1'b0;
   end

   // R6 R9
   chg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(changed) |-> $past(wr_byte_en || wr_half_en));

   // R9
   half_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_half_en |=> changed);
endmodule

// File: rtl/swin_ctrl.sv
module swin_ctrl #(
   parameter int                ADDR_W     = 24,
   parameter int                CYC_W      = 32,
   parameter int                DEPTH_LOG2 = 6,
   parameter int                EE_GAP     = 46,
   parameter bit                MEM_CLEAR  = 1'b1,
   parameter logic [ADDR_W-1:0] WIN_START  = 24'h200000,
   parameter logic [ADDR_W-1:0] WIN_END    = 24'h20FFFF,
   parameter logic [ADDR_W-1:0] EE_LO      = 24'h200000,
   parameter logic [ADDR_W-1:0] EE_HI      = 24'h200001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sram_en,
   input  logic              cfg_wr_dis,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [15:0]       bus_wdata,
   input  logic [CYC_W-1:0]  cpu_cyc,
   input  logic              ee_dout,
   input  logic              chg_clr,
   output logic              rd_hit,
   output logic [31:0]       rd_data,
   output logic              ee_strobe,
   output logic              ee_scl,
   output logic              ee_sda,
   output logic              save_changed
);
   import swin_pkg::*;

   if (DEPTH_LOG2 < 2 || DEPTH_LOG2 > 10) begin : g_bad_depth
      $error("swin_ctrl: DEPTH_LOG2 out of range");
   end
   if (EE_LO < WIN_START || EE_HI > WIN_END || EE_HI < EE_LO) begin : g_bad_win
      $error("swin_ctrl: EEPROM range must sit inside the default window");
   end
   if (EE_GAP < 1 || CYC_W < 8) begin : g_bad_gap
      $error("swin_ctrl: bad merge distance or cycle width");
   end

   logic [7:0]            mode;
   logic [ADDR_W-1:0]     win_lo, win_hi;
   logic                  served, rd_sel, wr_sel;
   logic                  fast_ok, half_wr, byte_path, ee_wr, sram_byte;
   logic                  pend_we;
   logic [1:0]            pend_val;
   logic [DEPTH_LOG2-1:0] idx;
   logic [7:0]            st_b0, st_b2, v0, v2;
   logic                  unused_mode;

   assign unused_mode = ^{mode[3], mode[5]};

   assign served  = (bus_addr >= win_lo) && (bus_addr <= win_hi) &&
                    (mode[MB_SRAM] || mode[MB_EE]);
   assign rd_sel  = bus_rd && served;
   assign wr_sel  = bus_wr && served;
   assign idx     = bus_addr[DEPTH_LOG2-1:0] - win_lo[DEPTH_LOG2-1:0];

   assign fast_ok   = mode[MB_DET] && !mode[MB_EE] && !mode[MB_WRDIS];
   assign half_wr   = wr_sel && (bus_size != SZ_BYTE) && fast_ok;
   assign byte_path = wr_sel && !half_wr;
   assign ee_wr     = byte_path && mode[MB_EE];
   assign sram_byte = byte_path && !mode[MB_EE] && !mode[MB_WRDIS];

   swin_mode #(
      .ADDR_W(ADDR_W), .WIN_START(WIN_START), .WIN_END(WIN_END),
      .EE_LO(EE_LO), .EE_HI(EE_HI)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .cfg_sram_en(cfg_sram_en), .cfg_wr_dis(cfg_wr_dis),
      .rd_sel(rd_sel), .wr_sel(wr_sel), .addr(bus_addr),
      .pend_we(pend_we), .pend_val(pend_val),
      .mode_q(mode), .win_lo(win_lo), .win_hi(win_hi)
   );

   swin_eecoal #(.CYC_W(CYC_W), .EE_GAP(EE_GAP)) u_coal (
      .clk(clk), .rst_n(rst_n), .ee_wr(ee_wr), .wr_bits(bus_wdata[1:0]),
      .cyc(cpu_cyc), .pend_cur({mode[MB_SCL], mode[MB_SDA]}),
      .pend_we(pend_we), .pend_val(pend_val),
      .ee_strobe(ee_strobe), .ee_scl(ee_scl), .ee_sda(ee_sda)
   );

   swin_store #(.DEPTH_LOG2(DEPTH_LOG2), .MEM_CLEAR(MEM_CLEAR)) u_store (
      .clk(clk), .rst_n(rst_n), .idx(idx), .wr_byte_en(sram_byte),
      .wr_half_en(half_wr), .wdata(bus_wdata), .chg_clr(chg_clr),
      .rd_b0(st_b0), .rd_b2(st_b2), .changed(save_changed)
   );

   assign v0 = mode[MB_EE] ? {7'b0, ee_dout} : st_b0;
   assign v2 = mode[MB_EE] ? {7'b0, ee_dout} : st_b2;

   always_comb begin
      rd_data = '0;
      if (rd_sel) begin
         case (bus_size)
            SZ_BYTE: rd_data = {24'b0, v0};
            SZ_HALF: rd_data = {16'b0, v0, v0};
            default: rd_data = {v0, v0, v2, v2};
         endcase
      end
   end
   assign rd_hit = rd_sel;

   // R11
   ee_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && mode[MB_EE]) |-> ((rd_data & 32'hFEFE_FEFE) == 32'h0));

   // R2
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rd_data == 32'h0));
endmodule

// File: tb/swin_ctrl_tb.sv
module swin_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_sram_en = 1'b0, cfg_wr_dis = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [31:0] cpu_cyc = '0;
   logic        ee_dout = 1'b0, chg_clr = 1'b0;
   logic        rd_hit, ee_strobe, ee_scl, ee_sda, save_changed;
   logic [31:0] rd_data;

   int checks = 0;
   int fails  = 0;
   logic [31:0] s_rd;
   logic        s_hit, s_ee, s_scl, s_sda, s_chg;

   always #(CLK_PERIOD/2) clk = ~clk;

   swin_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_sram_en(cfg_sram_en), .cfg_wr_dis(cfg_wr_dis),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .cpu_cyc(cpu_cyc), .ee_dout(ee_dout), .chg_clr(chg_clr),
      .rd_hit(rd_hit), .rd_data(rd_data), .ee_strobe(ee_strobe), .ee_scl(ee_scl),
      .ee_sda(ee_sda), .save_changed(save_changed)
   );

   typedef struct packed {
      logic        rd;
      logic        wr;
      logic [1:0]  sz;
      logic [23:0] addr;
      logic [15:0] data;
      logic        hit;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b1, 2'd0, 24'h200010, 16'h005A, 1'b0, 32'h0},
      '{1'b1, 1'b0, 2'd0, 24'h200010, 16'h0000, 1'b1, 32'h0000005A},
      '{1'b1, 1'b0, 2'd1, 24'h200010, 16'h0000, 1'b1, 32'h00005A5A},
      '{1'b0, 1'b1, 2'd1, 24'h200020, 16'hA1B2, 1'b0, 32'h0},
      '{1'b1, 1'b0, 2'd0, 24'h200020, 16'h0000, 1'b1, 32'h000000A1},
      '{1'b1, 1'b0, 2'd0, 24'h200021, 16'h0000, 1'b1, 32'h000000B2},
      '{1'b1, 1'b0, 2'd2, 24'h200010, 16'h0000, 1'b1, 32'h5A5A0000},
      '{1'b1, 1'b0, 2'd2, 24'h20001E, 16'h0000, 1'b1, 32'h0000A1A1},
      '{1'b1, 1'b0, 2'd0, 24'h1FFFFF, 16'h0000, 1'b0, 32'h0},
      '{1'b1, 1'b0, 2'd0, 24'h210000, 16'h0000, 1'b0, 32'h0},
      '{1'b0, 1'b1, 2'd0, 24'h20FFFF, 16'h0033, 1'b0, 32'h0},
      '{1'b1, 1'b0, 2'd0, 24'h20FFFF, 16'h0000, 1'b1, 32'h00000033},
      '{1'b1, 1'b0, 2'd1, 24'h20FFFF, 16'h0000, 1'b1, 32'h00003333}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic rd, input logic wr, input logic [1:0] sz,
                      input logic [23:0] a, input logic [15:0] d, input logic [31:0] cyc);
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = d; cpu_cyc = cyc;
      #2;
      s_rd = rd_data; s_hit = rd_hit;
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
      #1;
      s_ee = ee_strobe; s_scl = ee_scl; s_sda = ee_sda; s_chg = save_changed;
   endtask

   task automatic clr_pulse();
      @(negedge clk);
      chg_clr = 1'b1;
      @(negedge clk);
      chg_clr = 1'b0;
      #1;
      s_chg = save_changed;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 strobe after reset", {31'b0, ee_strobe}, 32'h0);
      check("R1 changed after reset", {31'b0, save_changed}, 32'h0);
      // R2 SRAM disabled -> falls through
      acc(1'b1, 1'b0, 2'd0, 24'h200000, 16'h0, 32'd0);
      check("R2 disabled miss hit", {31'b0, s_hit}, 32'h0);
      check("R2 disabled miss data", s_rd, 32'h0);
      cfg_sram_en = 1'b1;
      acc(1'b1, 1'b0, 2'd0, 24'h200000, 16'h0, 32'd0);
      check("R1 cleared byte hit", {31'b0, s_hit}, 32'h1);
      check("R1 cleared byte data", s_rd, 32'h0);
      // R10 halfword write before detection takes byte path
      acc(1'b0, 1'b1, 2'd1, 24'h200030, 16'h1234, 32'd0);
      acc(1'b1, 1'b0, 2'd1, 24'h200030, 16'h0, 32'd0);
      check("R10 undetected half write low byte", s_rd, 32'h00003434);
      acc(1'b1, 1'b0, 2'd0, 24'h200031, 16'h0, 32'd0);
      check("R10 undetected half write next byte", s_rd, 32'h0);

      // table walk: detected SRAM mode
      for (int i = 0; i < NV; i++) begin
         acc(VEC[i].rd, VEC[i].wr, VEC[i].sz, VEC[i].addr, VEC[i].data, 32'd0);
         if (VEC[i].rd) begin
            check($sformatf("R2/R8/R9 table %0d hit", i), {31'b0, s_hit}, {31'b0, VEC[i].hit});
            check($sformatf("R2/R8/R9 table %0d data", i), s_rd, VEC[i].exp);
         end
      end

      // R6 / R7 changed flag
      clr_pulse();
      check("R7 clear", {31'b0, s_chg}, 32'h0);
      acc(1'b0, 1'b1, 2'd0, 24'h200010, 16'h005A, 32'd0);
      check("R6 same value no change", {31'b0, s_chg}, 32'h0);
      acc(1'b0, 1'b1, 2'd0, 24'h200010, 16'h006B, 32'd0);
      check("R6 new value sets changed", {31'b0, s_chg}, 32'h1);
      acc(1'b1, 1'b0, 2'd0, 24'h200010, 16'h0, 32'd0);
      check("R6 new value stored", s_rd, 32'h0000006B);
      clr_pulse();
      cfg_wr_dis = 1'b1;
      acc(1'b0, 1'b1, 2'd0, 24'h200010, 16'h0077, 32'd0);
      check("R6 protected write no change", {31'b0, s_chg}, 32'h0);
      acc(1'b1, 1'b0, 2'd0, 24'h200010, 16'h0, 32'd0);
      check("R6 protected write dropped", s_rd, 32'h0000006B);
      acc(1'b0, 1'b1, 2'd1, 24'h200010, 16'hC3D4, 32'd0);
      acc(1'b1, 1'b0, 2'd1, 24'h200010, 16'h0, 32'd0);
      check("R10 protected half write dropped", s_rd, 32'h00006B6B);
      cfg_wr_dis = 1'b0;
      chg_clr = 1'b1;
      acc(1'b0, 1'b1, 2'd0, 24'h200010, 16'h0011, 32'd0);
      chg_clr = 1'b0;
      check("R7 set wins over clear", {31'b0, s_chg}, 32'h1);
      clr_pulse();
      acc(1'b0, 1'b1, 2'd1, 24'h200020, 16'hA1B2, 32'd0);
      check("R9 direct half write always sets changed", {31'b0, s_chg}, 32'h1);

      // R4 read detection
      do_reset();
      acc(1'b1, 1'b0, 2'd0, 24'h200010, 16'h0, 32'd0);
      acc(1'b0, 1'b1, 2'd0, 24'h200000, 16'h0099, 32'd0);
      acc(1'b1, 1'b0, 2'd0, 24'h200010, 16'h0, 32'd0);
      check("R4 window kept", {31'b0, s_hit}, 32'h1);
      acc(1'b1, 1'b0, 2'd0, 24'h200000, 16'h0, 32'd0);
      check("R4 plain SRAM byte", s_rd, 32'h00000099);
      acc(1'b0, 1'b1, 2'd1, 24'h200004, 16'h5566, 32'd0);
      acc(1'b1, 1'b0, 2'd0, 24'h200005, 16'h0, 32'd0);
      check("R4 detected enables direct half write", s_rd, 32'h00000066);

      // R3 / R11 / R5 EEPROM detection and coalescing
      do_reset();
      acc(1'b1, 1'b0, 2'd0, 24'h200001, 16'h0, 32'd0);
      acc(1'b0, 1'b1, 2'd0, 24'h200001, 16'h0003, 32'd100);
      check("R3 detecting write uses prior mode (changed)", {31'b0, s_chg}, 32'h1);
      check("R3 detecting write no strobe", {31'b0, s_ee}, 32'h0);
      acc(1'b1, 1'b0, 2'd0, 24'h200010, 16'h0, 32'd0);
      check("R3 window narrowed", {31'b0, s_hit}, 32'h0);
      ee_dout = 1'b1;
      acc(1'b1, 1'b0, 2'd0, 24'h200000, 16'h0, 32'd0);
      check("R11 byte read", s_rd, 32'h00000001);
      acc(1'b1, 1'b0, 2'd1, 24'h200000, 16'h0, 32'd0);
      check("R11 half read", s_rd, 32'h00000101);
      acc(1'b1, 1'b0, 2'd2, 24'h200000, 16'h0, 32'd0);
      check("R11 word read", s_rd, 32'h01010101);
      ee_dout = 1'b0;
      cfg_sram_en = 1'b0;
      acc(1'b1, 1'b0, 2'd0, 24'h200001, 16'h0, 32'd0);
      check("R2 EEPROM mode served without SRAM enable", {31'b0, s_hit}, 32'h1);
      check("R11 dout low", s_rd, 32'h0);
      clr_pulse();
      acc(1'b0, 1'b1, 2'd0, 24'h200000, 16'h0002, 32'd200);
      check("R5 first forward strobe", {31'b0, s_ee}, 32'h1);
      check("R5 first forward pair", {30'b0, s_scl, s_sda}, 32'h0);
      acc(1'b0, 1'b1, 2'd0, 24'h200000, 16'h0001, 32'd220);
      check("R5 merged no strobe", {31'b0, s_ee}, 32'h0);
      acc(1'b0, 1'b1, 2'd0, 24'h200000, 16'h0003, 32'd246);
      check("R5 gap 46 strobe", {31'b0, s_ee}, 32'h1);
      check("R5 gap 46 latest pending pair", {30'b0, s_scl, s_sda}, 32'h1);
      acc(1'b0, 1'b1, 2'd0, 24'h200000, 16'h0000, 32'd291);
      check("R5 gap 45 merged", {31'b0, s_ee}, 32'h0);
      check("R5 merged keeps outputs", {30'b0, s_scl, s_sda}, 32'h1);
      acc(1'b0, 1'b1, 2'd0, 24'h200001, 16'h0002, 32'd400);
      check("R5 late forward strobe", {31'b0, s_ee}, 32'h1);
      check("R5 late forward pair", {30'b0, s_scl, s_sda}, 32'h0);
      check("R5 EEPROM writes leave changed", {31'b0, s_chg}, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule